// File: doc/BRIEF.md
# Policy-Selectable Direct-Mapped Data Cache

This block is a direct-mapped data cache between a processor load/store port and a word-wide memory port. Every request carries three attribute bits, normally produced by address translation, that choose how that one access is handled. A single controller can therefore serve private data with write-back caching, shared buffers with write-through caching, streaming output that should not pollute the cache, and device registers that must never be cached.

The cache holds tag, valid and dirty state per line and one data word per entry in an inferable block RAM. Misses that allocate fetch the whole line as a four-beat burst. A dirty victim is first drained as a four-beat burst. Writes that do not allocate, write-through writes and uncached accesses use single-word transfers. The processor holds its request until the cache acknowledges it.

Attribute bits `cpu_attr` are {write_allocate, cacheable, write_back} from bit 2 down to bit 0. With the default parameters, an address splits into tag [31:8], line index [7:4], word offset [3:2] and byte bits [1:0].

Top module: `dcache_ctrl`

## Requirements
- R1: Synchronous reset clears every valid and dirty bit. After reset the acknowledge and memory valid outputs are low, and the first cacheable read of any line misses. A line that was dirty before the reset is not written back afterwards.
- R2: A cacheable read that hits returns the stored word and causes no memory transfer.
- R3: A cacheable read miss fetches the line as a four-beat burst read. The beats cover word offsets 0 to 3 in ascending order at the line's base address. The read returns the requested word, and later reads of that line hit.
- R4: A write hit with write_back=1 changes only the cached word and marks the line dirty. It causes no memory transfer.
- R5: When an allocating miss selects a valid dirty victim, the victim's four words are written to its own address as a burst before the refill read begins. A clean victim is dropped without any write.
- R6: With cacheable=1 and write_back=0, every write issues one single-word memory write with the request's address and data. On a hit the cached word is also updated. On a miss no line is allocated and the resident line is kept.
- R7: A write miss with cacheable=1, write_back=1 and write_allocate=0 issues one single-word memory write. It allocates nothing, and the resident line keeps its data and its dirty state.
- R8: A write miss with cacheable=1, write_back=1 and write_allocate=1 refills the line, merges the write word into it and marks it dirty. A later eviction writes back the merged word.
- R9: With cacheable=0 an access performs exactly one single-word memory transfer and neither reads nor changes the cache. A read returns memory data even when the address is cached, and a write leaves the cached copy intact.
- R10: While `mem_valid` is high and `mem_ready` is low, the memory outputs hold steady. `mem_burst` marks line transfers, and `mem_last` is high only on the final beat, which is also the only beat of a single transfer.
- R11: `cpu_ack` is a one-cycle pulse per request, and `cpu_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | DATA_W | Write data |
| cpu_attr | input | 3 | {write_allocate, cacheable, write_back} |
| cpu_ack | output | 1 | Access complete, one cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack |
| mem_valid | output | 1 | Memory beat offered |
| mem_we | output | 1 | Beat is a write |
| mem_burst | output | 1 | Beat belongs to a four-beat line transfer |
| mem_last | output | 1 | Final beat of the transfer |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | DATA_W | Beat write data |
| mem_ready | input | 1 | Memory accepts the beat (and returns read data) this cycle |
| mem_rdata | input | DATA_W | Read data, valid when a read beat is accepted |

## Verification
Cached reads are swept over every line and every word offset, which separates miss fills from hits by their memory traffic and returned data. Writes are then applied with each attribute combination to lines in known states (clean, dirty, resident under another tag). Counting and decoding the resulting beats separates the write-back, write-through, no-allocate, allocate-and-merge and bypass paths, since each leaves a distinct number, kind and order of transfers. Evictions of merged and write-through-modified lines check the write-back data word by word. A mid-run reset followed by a read of a formerly dirty line shows that the dirty state was cleared. The memory model withholds ready every third cycle, so every path also runs under back-pressure.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WBACK,
    S_FILL,
    S_SINGLE,
    S_RESP
  } dc_state_t;

  typedef struct packed {
    logic wr_alloc;
    logic cacheable;
    logic wback;
  } dc_attr_t;
endpackage

// File: rtl/dcache_tagstore.sv
module dcache_tagstore #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_dirty,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // state bits need reset; tag array does not, so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (upd_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= upd_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) tag_q[idx] <= upd_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];
endmodule

// File: rtl/dcache_dataram.sv
module dcache_dataram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [2:0]        cpu_attr,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic              mem_burst,
  output logic              mem_last,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int RAM_AW = IDX_W + OFF_W;

  dc_state_t         state_q;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  dc_attr_t          r_attr;
  logic [OFF_W-1:0]  beat_q;
  logic [DATA_W-1:0] rdata_q;

  // request fields
  logic [TAG_W-1:0] r_tag;
  logic [IDX_W-1:0] r_idx, cpu_idx;
  logic [OFF_W-1:0] r_off, cpu_off;
  assign r_tag   = r_addr[ADDR_W-1 -: TAG_W];
  assign r_idx   = r_addr[BYTE_W+OFF_W +: IDX_W];
  assign r_off   = r_addr[BYTE_W +: OFF_W];
  assign cpu_idx = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign cpu_off = cpu_addr[BYTE_W +: OFF_W];

  // tag store
  logic             t_valid, t_dirty, upd_en, upd_dirty;
  logic [TAG_W-1:0] t_tag;

  dcache_tagstore #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(r_idx),
    .upd_en(upd_en), .upd_tag(r_tag), .upd_dirty(upd_dirty),
    .line_valid(t_valid), .line_dirty(t_dirty), .line_tag(t_tag)
  );

  // data store
  logic [RAM_AW-1:0] ram_raddr, ram_waddr;
  logic [DATA_W-1:0] ram_q, ram_wdata;
  logic              ram_we;

  dcache_dataram #(.DATA_W(DATA_W), .DEPTH(LINES * WORDS)) u_data (
    .clk(clk), .raddr(ram_raddr), .rdata(ram_q),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );

  logic             hit, hs, last_beat, alloc;
  logic [OFF_W-1:0] beat_n;

  assign hit       = t_valid && (t_tag == r_tag);
  assign hs        = mem_valid && mem_ready;
  assign last_beat = beat_q == OFF_W'(WORDS - 1);
  assign alloc     = !r_we || (r_attr.wback && r_attr.wr_alloc);
  assign beat_n    = (state_q == S_WBACK && hs) ? beat_q + OFF_W'(1) : beat_q;

  // the RAM output must already show the next victim word when a write-back beat is taken
  assign ram_raddr = (state_q == S_IDLE) ? {cpu_idx, cpu_off} : {r_idx, beat_n};

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {r_idx, r_off};
    ram_wdata = r_wdata;
    upd_en    = 1'b0;
    upd_dirty = 1'b0;
    if (state_q == S_LOOK && r_attr.cacheable && hit && r_we) begin
      ram_we    = 1'b1;
      upd_en    = 1'b1;
      upd_dirty = r_attr.wback | t_dirty;
    end
    if (state_q == S_FILL && hs) begin
      ram_we    = 1'b1;
      ram_waddr = {r_idx, beat_q};
      ram_wdata = (r_we && beat_q == r_off) ? r_wdata : mem_rdata;
      if (last_beat) begin
        upd_en    = 1'b1;
        upd_dirty = r_we;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_attr  <= '0;
      beat_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          beat_q <= '0;
          if (cpu_req) begin
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
            r_attr  <= cpu_attr;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (!r_attr.cacheable) begin
            state_q <= S_SINGLE;
          end else if (hit) begin
            rdata_q <= ram_q;
            state_q <= (r_we && !r_attr.wback) ? S_SINGLE : S_RESP;
          end else if (alloc) begin
            state_q <= (t_valid && t_dirty) ? S_WBACK : S_FILL;
          end else begin
            state_q <= S_SINGLE;
          end
        end
        S_WBACK: begin
          if (hs) begin
            beat_q <= beat_q + OFF_W'(1);
            if (last_beat) state_q <= S_FILL;
          end
        end
        S_FILL: begin
          if (hs) begin
            beat_q <= beat_q + OFF_W'(1);
            if (beat_q == r_off) rdata_q <= mem_rdata;
            if (last_beat) state_q <= S_RESP;
          end
        end
        S_SINGLE: begin
          if (hs) begin
            if (!r_we) rdata_q <= mem_rdata;
            state_q <= S_RESP;
          end
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ack   = state_q == S_RESP;
  assign cpu_rdata = rdata_q;
  assign mem_burst = (state_q == S_WBACK) || (state_q == S_FILL);
  assign mem_valid = mem_burst || (state_q == S_SINGLE);
  assign mem_we    = (state_q == S_WBACK) || (state_q == S_SINGLE && r_we);
  assign mem_last  = mem_valid && (!mem_burst || last_beat);
  assign mem_wdata = (state_q == S_WBACK) ? ram_q : r_wdata;

  always_comb begin
    case (state_q)
      S_WBACK: mem_addr = {t_tag, r_idx, beat_q, {BYTE_W{1'b0}}};
      S_FILL:  mem_addr = {r_tag, r_idx, beat_q, {BYTE_W{1'b0}}};
      default: mem_addr = r_addr;
    endcase
  end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ack,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_burst,
  input logic              mem_last,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(WORDS);

  // R1: leaving reset, nothing is acknowledged or offered to memory
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cpu_ack && !mem_valid));

  // R10: a stalled beat keeps every memory output steady
  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_burst) && $stable(mem_last)));

  // R10: last-beat flag only accompanies an offered beat
  p_last_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    mem_last |-> mem_valid);

  // R10: single transfers are one beat; a burst ends on the top word of the line
  p_single_is_last_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_burst) |-> mem_last);

  p_burst_end_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_burst && mem_last) |-> (mem_addr[BYTE_W +: OFF_W] == {OFF_W{1'b1}}));

  // R11: acknowledge lasts exactly one cycle
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_burst(mem_burst), .mem_last(mem_last), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
  localparam logic [2:0] A_RWA = 3'b111;
  localparam logic [2:0] A_RA  = 3'b011;
  localparam logic [2:0] A_WT  = 3'b010;
  localparam logic [2:0] A_UC  = 3'b000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [2:0]  cpu_attr = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_we, mem_burst, mem_last;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  dcache_ctrl uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_attr(cpu_attr), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_burst(mem_burst), .mem_last(mem_last),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] fm(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] ad(input int tag, input int idx, input int off);
    return (32'(tag) << 8) | (32'(idx) << 4) | (32'(off) << 2);
  endfunction

  function automatic logic [31:0] vw(input int idx); return 32'h1000_0000 + 32'(idx); endfunction
  function automatic logic [31:0] tw(input int idx); return 32'h2000_0000 + 32'(idx); endfunction

  // memory model: data computed from address, ready withheld every third cycle
  assign mem_rdata = mem_valid ? fm(mem_addr) : '0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ready = (cyc % 3) != 0;
  end

  // transfer log and stall monitor
  logic [31:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic        lg_we [256];
  logic        lg_burst [256];
  logic        lg_last [256];
  int          n_tx = 0;
  int          mon_checks = 0, mon_errs = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      prev_stall <= 1'b0;
    end else begin
      if (prev_stall) begin
        mon_checks <= mon_checks + 1;
        if (!mem_valid || mem_addr !== prev_addr) begin
          mon_errs <= mon_errs + 1;
          $display("FAIL R10 stalled beat changed: actual %h expected %h", mem_addr, prev_addr);
        end
      end
      prev_stall <= mem_valid && !mem_ready;
      prev_addr  <= mem_addr;
      if (mem_valid && mem_ready) begin
        lg_addr[n_tx & 255]  <= mem_addr;
        lg_data[n_tx & 255]  <= mem_wdata;
        lg_we[n_tx & 255]    <= mem_we;
        lg_burst[n_tx & 255] <= mem_burst;
        lg_last[n_tx & 255]  <= mem_last;
        n_tx <= n_tx + 1;
      end
    end
  end

  int checks = 0, errors = 0, base = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    chk(req, 32'(n_tx - base), 32'(exp));
  endtask

  task automatic chk_beat(input string req, input int k, input logic we, input logic [31:0] a,
                          input logic burst, input logic last);
    int j;
    j = (base + k) & 255;
    chk(req, lg_addr[j], a);
    chk(req, {31'b0, lg_we[j]}, {31'b0, we});
    chk(req, {31'b0, lg_burst[j]}, {31'b0, burst});
    chk(req, {31'b0, lg_last[j]}, {31'b0, last});
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [2:0] at, output logic [31:0] rd);
    int waited;
    @(negedge clk);
    base = n_tx;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_attr = at;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!cpu_ack && waited < 500);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    chk("R11 ack pulse", {31'b0, cpu_ack}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack idle after reset", {31'b0, cpu_ack}, 32'd0);
    chk("R1 mem idle after reset", {31'b0, mem_valid}, 32'd0);

    // R1/R3: every line misses after reset and fills as an ascending burst
    for (int i = 0; i < 16; i++) begin
      access(1'b0, ad(1, i, i % 4), '0, A_RA, rd);
      chk("R3 miss data", rd, fm(ad(1, i, i % 4)));
      chk_cnt("R1 miss after reset", 4);
      for (int k = 0; k < 4; k++) chk_beat("R3 fill beat", k, 1'b0, ad(1, i, k), 1'b1, k == 3);
    end
    // R2: all words hit
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 4; o++) begin
        access(1'b0, ad(1, i, o), '0, A_RA, rd);
        chk("R2 hit data", rd, fm(ad(1, i, o)));
        chk_cnt("R2 hit no traffic", 0);
      end
    // R4: write-back hits stay in the cache
    for (int i = 0; i < 16; i++) begin
      access(1'b1, ad(1, i, 0), vw(i), A_RA, rd);
      chk_cnt("R4 wb hit no traffic", 0);
      access(1'b0, ad(1, i, 0), '0, A_RA, rd);
      chk("R4 wb hit data", rd, vw(i));
    end
    // R6: write-through hits go to memory and to the cache
    for (int i = 0; i < 16; i++) begin
      access(1'b1, ad(1, i, 1), tw(i), A_WT, rd);
      chk_cnt("R6 wt hit one write", 1);
      chk_beat("R6 wt beat", 0, 1'b1, ad(1, i, 1), 1'b0, 1'b1);
      chk("R6 wt data", lg_data[base & 255], tw(i));
      access(1'b0, ad(1, i, 1), '0, A_RA, rd);
      chk("R6 wt cached", rd, tw(i));
      chk_cnt("R6 wt cached hit", 0);
    end
    // R7: no-allocate write miss leaves resident dirty line alone
    access(1'b1, ad(5, 2, 0), 32'hCAFE_0007, A_RA, rd);
    chk_cnt("R7 one write", 1);
    chk_beat("R7 beat", 0, 1'b1, ad(5, 2, 0), 1'b0, 1'b1);
    chk("R7 data", lg_data[base & 255], 32'hCAFE_0007);
    access(1'b0, ad(1, 2, 0), '0, A_RA, rd);
    chk("R7 resident kept", rd, vw(2));
    chk_cnt("R7 resident hit", 0);
    // R6: write-through miss does not allocate
    access(1'b1, ad(6, 3, 0), 32'hBEEF_0006, A_WT, rd);
    chk_cnt("R6 wt miss one write", 1);
    chk_beat("R6 wt miss beat", 0, 1'b1, ad(6, 3, 0), 1'b0, 1'b1);
    access(1'b0, ad(1, 3, 0), '0, A_RA, rd);
    chk("R6 resident kept", rd, vw(3));
    chk_cnt("R6 resident hit", 0);
    // R5: dirty victim drained before refill
    access(1'b0, ad(2, 4, 2), '0, A_RA, rd);
    chk("R5 refill data", rd, fm(ad(2, 4, 2)));
    chk_cnt("R5 eight beats", 8);
    for (int k = 0; k < 4; k++) chk_beat("R5 victim beat", k, 1'b1, ad(1, 4, k), 1'b1, k == 3);
    chk("R5 victim w0", lg_data[(base + 0) & 255], vw(4));
    chk("R5 victim w1", lg_data[(base + 1) & 255], tw(4));
    chk("R5 victim w2", lg_data[(base + 2) & 255], fm(ad(1, 4, 2)));
    chk("R5 victim w3", lg_data[(base + 3) & 255], fm(ad(1, 4, 3)));
    for (int k = 0; k < 4; k++) chk_beat("R5 refill beat", 4 + k, 1'b0, ad(2, 4, k), 1'b1, k == 3);
    // R8: allocating write miss merges and dirties
    access(1'b1, ad(3, 5, 1), 32'hD00D_0005, A_RWA, rd);
    chk_cnt("R8 eight beats", 8);
    for (int k = 0; k < 4; k++) chk_beat("R8 victim beat", k, 1'b1, ad(1, 5, k), 1'b1, k == 3);
    for (int k = 0; k < 4; k++) chk_beat("R8 refill beat", 4 + k, 1'b0, ad(3, 5, k), 1'b1, k == 3);
    access(1'b0, ad(3, 5, 1), '0, A_RA, rd);
    chk("R8 merged word", rd, 32'hD00D_0005);
    chk_cnt("R8 merged hit", 0);
    access(1'b0, ad(3, 5, 2), '0, A_RA, rd);
    chk("R8 other word", rd, fm(ad(3, 5, 2)));
    access(1'b0, ad(4, 5, 0), '0, A_RA, rd);
    chk_cnt("R8 evict eight beats", 8);
    for (int k = 0; k < 4; k++) begin
      chk_beat("R8 evict beat", k, 1'b1, ad(3, 5, k), 1'b1, k == 3);
      chk("R8 evict data", lg_data[(base + k) & 255], (k == 1) ? 32'hD00D_0005 : fm(ad(3, 5, k)));
    end
    // R5: clean victim dropped
    access(1'b0, ad(8, 5, 3), '0, A_RA, rd);
    chk_cnt("R5 clean victim four beats", 4);
    chk_beat("R5 clean first beat read", 0, 1'b0, ad(8, 5, 0), 1'b1, 1'b0);
    // R9: bypass
    access(1'b0, ad(1, 6, 0), '0, A_UC, rd);
    chk("R9 bypass read memory data", rd, fm(ad(1, 6, 0)));
    chk_cnt("R9 one beat", 1);
    chk_beat("R9 read beat", 0, 1'b0, ad(1, 6, 0), 1'b0, 1'b1);
    access(1'b1, ad(1, 6, 0), 32'hE0E0_0009, A_UC, rd);
    chk_cnt("R9 one write", 1);
    chk("R9 write data", lg_data[base & 255], 32'hE0E0_0009);
    access(1'b0, ad(1, 6, 0), '0, A_RA, rd);
    chk("R9 cache untouched", rd, vw(6));
    chk_cnt("R9 cache hit", 0);
    // R1: reset drops dirty lines without write-back
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after second reset", {31'b0, mem_valid}, 32'd0);
    access(1'b0, ad(1, 6, 0), '0, A_RA, rd);
    chk_cnt("R1 dirty cleared", 4);
    chk_beat("R1 refill only", 0, 1'b0, ad(1, 6, 0), 1'b1, 1'b0);
    chk("R1 data from memory", rd, fm(ad(1, 6, 0)));

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
    $finish;
  end
endmodule